// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four independent pulse-width-modulated outputs, each one set up through a plain 32-bit register bus. Every channel has a clock divider, an 8-bit period length, a 16-bit high-time count and an on/off control. A channel's step counter advances once every (divider + 1) clock cycles and wraps after the period length. The output is high while the step count is below the high-time count.

Software stages a new period length first. Writing the high-time count commits the staged pair. The committed pair does not reach the output at once: it waits until the period that is running ends, so no period ever mixes old and new settings. A new divider value is taken at the same period boundary. Switching a channel off does not wait. The output drops on the next cycle and both counters return to zero. Switching it back on starts a new period from step zero.

Top module: `mchan_pwm`

## Requirements
- R1: Channel n's registers sit at byte address n*0x20 plus an offset: divider at 0x00, period length at 0x04, high-time count at 0x08, on/off control at 0x18. Each register reads back the value last written to it.
- R2: The divider and the period length keep bits 7:0, the high-time count keeps bits 15:0 and the on/off control keeps bit 0. All other bits read as zero, and any other offset inside a channel reads as zero.
- R3: With divider P, period length M and high-time count D (0 < D < M), the output is high for the first (P+1)*D cycles of each period of (P+1)*M cycles.
- R4: If D >= M, the output stays high for the whole period. If D = 0 or M = 0, the output stays low.
- R5: Writing the period length alone leaves the output unchanged. The staged value is used only after a later write to the high-time count.
- R6: A write to the high-time count, made while the channel runs, takes effect at the start of the next period. The period that is running finishes with its old settings.
- R7: A divider write made while the channel runs takes effect at the next period boundary.
- R8: Writing 0 to the on/off control drives the output low on the next clock cycle, whatever the phase of the period.
- R9: A channel that is off holds its output low. Turning it on starts a new period whose first cycle is high when D is nonzero.
- R10: Channels run independently. One channel's settings do not change another channel's output.
- R11: After reset all outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The divider, period length and high-time count are set to several combinations, and the high cycles are counted over windows that span whole periods. A window that starts at the moment the channel is switched on also pins down where the high run sits inside the period. Mid-period writes of the high-time count and the divider are followed by a count over the rest of the running period and then over the next full period. This separates a change that is deferred to the boundary from one that is applied at once. A staged period length with no later commit must leave the duty ratio as it was. Two channels run at the same time with different settings, which shows whether their outputs stay separate.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  // Register offsets inside one channel window
  localparam int OFS_PRE  = 'h00;
  localparam int OFS_MOD  = 'h04;
  localparam int OFS_DUTY = 'h08;
  localparam int OFS_EN   = 'h18;

  // Output level for a given step count
  function automatic logic level_at(input logic [31:0] cnt,
                                    input logic [31:0] modv,
                                    input logic [31:0] duty);
    return (modv != 32'd0) && (cnt < duty);
  endfunction

  // True on the final step of a period (a zero period ends on every step)
  function automatic logic last_step(input logic [31:0] cnt,
                                     input logic [31:0] modv);
    return (modv == 32'd0) || (cnt + 32'd1 >= modv);
  endfunction
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs #(
  parameter int CH_IDX = 0,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int CH_SH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              load,
  output logic [PRE_W-1:0]  pre_q,
  output logic              en_q,
  output logic              pend_q,
  output logic [MOD_W-1:0]  pend_mod,
  output logic [DUTY_W-1:0] pend_duty,
  output logic [DATA_W-1:0] rd_word
);
  localparam int SEL_W = ADDR_W - CH_SH;

  logic [MOD_W-1:0]  mod_q;
  logic [DUTY_W-1:0] duty_q;
  logic              hit;
  int                ofs;

  always_comb begin
    hit = bus_wr && (bus_addr[ADDR_W-1:CH_SH] == SEL_W'(CH_IDX));
    ofs = int'(bus_addr[CH_SH-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      mod_q     <= '0;
      duty_q    <= '0;
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      pend_mod  <= '0;
      pend_duty <= '0;
    end else begin
      if (load) pend_q <= 1'b0;
      if (hit) begin
        if (ofs == pwmq_pkg::OFS_PRE) pre_q <= bus_wdata[PRE_W-1:0];
        if (ofs == pwmq_pkg::OFS_MOD) mod_q <= bus_wdata[MOD_W-1:0];
        if (ofs == pwmq_pkg::OFS_EN)  en_q  <= bus_wdata[0];
        if (ofs == pwmq_pkg::OFS_DUTY) begin
          duty_q    <= bus_wdata[DUTY_W-1:0];
          pend_mod  <= mod_q;
          pend_duty <= bus_wdata[DUTY_W-1:0];
          pend_q    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (ofs == pwmq_pkg::OFS_PRE)  rd_word = DATA_W'(pre_q);
    if (ofs == pwmq_pkg::OFS_MOD)  rd_word = DATA_W'(mod_q);
    if (ofs == pwmq_pkg::OFS_DUTY) rd_word = DATA_W'(duty_q);
    if (ofs == pwmq_pkg::OFS_EN)   rd_word = DATA_W'(en_q);
  end
endmodule

// File: rtl/pwmq_engine.sv
module pwmq_engine #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  pre_q,
  input  logic              pend_q,
  input  logic [MOD_W-1:0]  pend_mod,
  input  logic [DUTY_W-1:0] pend_duty,
  output logic              load,
  output logic [MOD_W-1:0]  act_mod,
  output logic              pwm
);
  logic [PRE_W-1:0]  act_pre;
  logic [DUTY_W-1:0] act_duty;
  logic [PRE_W-1:0]  pre_cnt;
  logic [MOD_W-1:0]  per_cnt;
  logic              tick, last, period_end;

  always_comb begin
    tick       = (pre_cnt == act_pre);
    last       = pwmq_pkg::last_step(32'(per_cnt), 32'(act_mod));
    period_end = en && tick && last;
    load       = !en || period_end;
    pwm        = en && pwmq_pkg::level_at(32'(per_cnt), 32'(act_mod), 32'(act_duty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      per_cnt  <= '0;
      act_pre  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
    end else begin
      if (!en) begin
        pre_cnt <= '0;
        per_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        per_cnt <= last ? '0 : per_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (load) begin
        act_pre <= pre_q;
        if (pend_q) begin
          act_mod  <= pend_mod;
          act_duty <= pend_duty;
        end
      end
    end
  end
endmodule

// File: rtl/mchan_pwm.sv
module mchan_pwm #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int CH_SH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int SEL_W = ADDR_W - CH_SH;

  logic [NUM_CH-1:0]       ch_en, ch_pend, ch_load;
  logic [NUM_CH*MOD_W-1:0] ch_act_mod;
  logic [DATA_W-1:0]       rd_words [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PRE_W-1:0]  pre_q;
    logic [MOD_W-1:0]  pend_mod;
    logic [DUTY_W-1:0] pend_duty;

    pwmq_regs #(
      .CH_IDX(c), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W),
      .MOD_W(MOD_W), .DUTY_W(DUTY_W), .CH_SH(CH_SH)
    ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .load(ch_load[c]), .pre_q(pre_q),
      .en_q(ch_en[c]), .pend_q(ch_pend[c]), .pend_mod(pend_mod),
      .pend_duty(pend_duty), .rd_word(rd_words[c])
    );

    pwmq_engine #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .pre_q(pre_q),
      .pend_q(ch_pend[c]), .pend_mod(pend_mod), .pend_duty(pend_duty),
      .load(ch_load[c]), .act_mod(ch_act_mod[c*MOD_W +: MOD_W]),
      .pwm(pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr[ADDR_W-1:CH_SH] == SEL_W'(c)) bus_rdata = rd_words[c];
  end
endmodule

// File: rtl/pwmq_chk.sv
module pwmq_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MOD_W  = 8,
  parameter int CH_SH  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [NUM_CH-1:0]   pwm_out,
  input logic [NUM_CH-1:0]   ch_pend,
  input logic [NUM_CH-1:0]   ch_load,
  input logic [NUM_CH*MOD_W-1:0] ch_act_mod
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'((c << CH_SH) + pwmq_pkg::OFS_EN);
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'((c << CH_SH) + pwmq_pkg::OFS_DUTY);

    // R8
    stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_EN && !bus_wdata[0]) |=> !pwm_out[c]);
    // R6
    commit_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DUTY) |=> ch_pend[c]);
    // R6
    commit_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_pend[c]) |-> $past(ch_load[c]));
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_load[c] |=> $stable(ch_act_mod[c*MOD_W +: MOD_W]));
    // R4
    zero_mod_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_act_mod[c*MOD_W +: MOD_W] == '0) |-> !pwm_out[c]);
  end
endmodule

bind mchan_pwm pwmq_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MOD_W(MOD_W), .CH_SH(CH_SH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pwm_out(pwm_out), .ch_pend(ch_pend),
  .ch_load(ch_load), .ch_act_mod(ch_act_mod)
);

// File: tb/mchan_pwm_tb.sv
module mchan_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int errors = 0;
  int checks = 0;
  int hi [4];
  bit done = 1'b0;

  localparam int PRE = 'h00, MODR = 'h04, DUTY = 'h08, ENR = 'h18;

  mchan_pwm u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the write done
  task automatic wr(int ch, int ofs, logic [31:0] d);
    bus_addr = 8'(ch * 32 + ofs);
    bus_wdata = d;
    bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int ch, int ofs, int exp, string req);
    bus_addr = 8'(ch * 32 + ofs);
    #1;
    check(req, int'(bus_rdata), exp);
  endtask

  // Count high cycles per channel over n cycles
  task automatic measure(int n);
    for (int c = 0; c < 4; c++) hi[c] = 0;
    repeat (n) begin
      for (int c = 0; c < 4; c++) if (pwm_out[c]) hi[c]++;
      @(negedge clk);
    end
  endtask

  task automatic setup(int ch, int p, int m, int d);
    wr(ch, ENR, 0);
    wr(ch, PRE, p);
    wr(ch, MODR, m);
    wr(ch, DUTY, d);
    wr(ch, ENR, 1);
  endtask

  task automatic t_reset;
    check("R11 outputs", int'(pwm_out), 0);
    rd(0, ENR, 0, "R11 enable");
    rd(3, DUTY, 0, "R11 duty");
  endtask

  task automatic t_map;
    wr(3, PRE, 32'h12);
    wr(3, MODR, 32'h34);
    wr(3, DUTY, 32'h5678);
    rd(3, PRE, 'h12, "R1 divider");
    rd(3, MODR, 'h34, "R1 period");
    rd(3, DUTY, 'h5678, "R1 duty");
    rd(1, PRE, 0, "R1 other channel");
  endtask

  task automatic t_width;
    wr(2, PRE, 32'hFFFF_FFFF);
    wr(2, MODR, 32'hFFFF_FFFF);
    wr(2, DUTY, 32'hFFFF_FFFF);
    wr(2, ENR, 32'hFFFF_FFFF);
    rd(2, PRE, 'hFF, "R2 divider");
    rd(2, MODR, 'hFF, "R2 period");
    rd(2, DUTY, 'hFFFF, "R2 duty");
    rd(2, ENR, 1, "R2 enable");
    rd(2, 'h0C, 0, "R2 hole");
    wr(2, ENR, 0);
  endtask

  task automatic t_shape;
    setup(0, 2, 5, 2);
    measure(6);
    check("R3 first run high", hi[0], 6);
    measure(9);
    check("R3 rest low", hi[0], 0);
    measure(30);
    check("R3 two periods", hi[0], 12);
  endtask

  task automatic t_limits;
    setup(0, 0, 8, 20);
    measure(16);
    check("R4 duty>=mod", hi[0], 16);
    setup(0, 1, 6, 0);
    measure(24);
    check("R4 duty zero", hi[0], 0);
    setup(0, 0, 0, 5);
    measure(20);
    check("R4 mod zero", hi[0], 0);
  endtask

  task automatic t_stage;
    setup(0, 0, 10, 4);
    wr(0, MODR, 5);
    measure(20);
    check("R5 staged only", hi[0], 8);
    wr(0, DUTY, 4);
    measure(10);
    measure(20);
    check("R5 after commit", hi[0], 16);
  endtask

  task automatic t_defer;
    setup(0, 0, 10, 3);
    measure(4);
    wr(0, DUTY, 7);
    measure(5);
    check("R6 running period", hi[0], 0);
    measure(10);
    check("R6 next period", hi[0], 7);
  endtask

  task automatic t_prescale;
    setup(0, 0, 10, 5);
    measure(2);
    wr(0, PRE, 1);
    measure(7);
    check("R7 running period", hi[0], 2);
    measure(20);
    check("R7 next period", hi[0], 10);
  endtask

  task automatic t_onoff;
    setup(0, 0, 8, 3);
    check("R9 first cycle high", int'(pwm_out[0]), 1);
    wr(0, ENR, 0);
    check("R8 immediate stop", int'(pwm_out[0]), 0);
    measure(10);
    check("R9 off stays low", hi[0], 0);
    measure(3);
    wr(0, ENR, 1);
    check("R9 restart high", int'(pwm_out[0]), 1);
    measure(8);
    check("R9 fresh period", hi[0], 3);
    wr(0, ENR, 0);
  endtask

  task automatic t_indep;
    setup(1, 0, 4, 1);
    setup(3, 1, 3, 2);
    measure(24);
    check("R10 ch1", hi[1], 6);
    check("R10 ch3", hi[3], 16);
    check("R10 ch0 idle", hi[0], 0);
    wr(1, ENR, 0);
    wr(3, ENR, 0);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_width;
    t_shape;
    t_limits;
    t_stage;
    t_defer;
    t_prescale;
    t_onoff;
    t_indep;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule